// File: doc/BRIEF.md
# Button Input Interrupt Controller

This block watches up to four digital pins that carry push buttons or accessory-detect switches. Each pin has its own conditioning. A pin can pass through a tick-driven filter that accepts a new level only once that level has stayed put for a set number of sample pulses. A pin can instead bypass the filter. In that case a flop clocked by the pin itself catches the edge, and the interrupt rises with no system clock running, so a halted host can be woken.

A detected edge sets a sticky status bit. Per-pin polarity chooses whether a rising or a falling edge counts. Per-pin enables decide which status bits drive the single shared interrupt line. A host uses a small register port to set the function code, enable, bypass and polarity of each pin, to read the latched status at any time, and to clear status bits by writing ones to them.

No data stream crosses this block, so there is no valid/ready handshake and no back-pressure. Every pin is a plain level input. The register port takes one write per cycle, and a read returns data in the same cycle as the address.

Top module: `btn_irq_ctrl`

## Requirements
- R1: `irq` is high exactly when some pin i has enable bit i set and its visible status bit set. Enabling a pin whose status is already set raises `irq` at once.
- R2: Pin i is a button input only when bits [4i+3:4i] of the function register (address 0) equal 4'b0000. With any other code, edges on that pin set no status and raise no interrupt.
- R3: With bypass bit i clear, a level change on pin i is accepted only after it has held for DEB_TICKS (default 4) consecutive `sample_tick` pulses. A shorter excursion sets nothing.
- R4: Polarity bit i (address 3) set to 0 makes a rising edge (0 to 1) the event. Set to 1, it makes a falling edge the event. An edge in the other direction sets nothing.
- R5: Status bits (address 4) stay set until the host writes 1 to that bit position. A written 0 leaves its bit unchanged.
- R6: If a filtered event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R7: Enable bits live at address 1. A pin with its enable clear still sets its status bit but does not drive `irq`.
- R8: With bypass bit i set (address 2), an event edge on pin i raises `irq` (if enabled) with no clock edge at all.
- R9: A bypassed pin's captured event appears in the status register within three clock cycles, through a two-flop synchronizer. A write-1 clear removes it, and `irq` falls with it.
- R10: After reset, every register reads 0 and `irq` is low. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (may be stopped while waiting for a wake edge) |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_tick | input | 1 | Single-cycle slow sample enable for the filters |
| pins | input | 4 | Raw button pin levels, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr`, same cycle |
| irq | output | 1 | Shared active-high interrupt request |

## Verification
The assertions assume that `sample_tick` is a one-cycle pulse and that a pin holds its new level for at least three clock cycles before the first tick that should count. The bench keeps to this by moving pins only on falling clock edges and then waiting three cycles before it issues ticks. The assertions also assume that the clock is stopped only while no clear pulse is pending, and that polarity and bypass settings do not change while a pin is moving. The bench stops the clock only after every write has finished, and it reprograms polarity and bypass only while the pins are at rest.

// File: rtl/btn_irq_pkg.sv
package btn_irq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_FUNC   = 3'd0,
    RA_ENABLE = 3'd1,
    RA_BYPASS = 3'd2,
    RA_POL    = 3'd3,
    RA_STATUS = 3'd4
  } reg_addr_e;

  localparam logic [3:0] FUNC_BUTTON = 4'b0000;
endpackage

// File: rtl/btn_sync2.sv
module btn_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic din,
  output logic lvl,
  output logic accept
);
  localparam int CW = (TICKS < 2) ? 1 : $clog2(TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign accept = tick && (din != lvl) && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl   <= 1'b0;
      cnt_q <= '0;
    end else if (tick) begin
      if (din == lvl) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        lvl   <= din;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_LEVEL_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl) |-> $past(tick)); // R3
  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(TICKS)); // R3
endmodule

// File: rtl/btn_wake_latch.sv
module btn_wake_latch (
  input  logic edge_in,
  input  logic aclr,
  output logic q
);
  always_ff @(posedge edge_in or posedge aclr) begin
    if (aclr) q <= 1'b0;
    else      q <= 1'b1;
  end
endmodule

// File: rtl/btn_irq_ctrl.sv
module btn_irq_ctrl
  import btn_irq_pkg::*;
#(
  parameter int NPINS     = 4,
  parameter int SEL_W     = 4,
  parameter int DEB_TICKS = 4,
  parameter int DW        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_tick,
  input  logic [NPINS-1:0]  pins,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data,
  output logic              irq
);
  localparam int SELB = NPINS * SEL_W;

  logic [SELB-1:0]  sel_q;
  logic [NPINS-1:0] en_q, byp_q, pol_q, st_q, clr_q;
  logic [NPINS-1:0] clr_now, st_n, evt, active, arm, aclr, edge_in;
  logic [NPINS-1:0] pin_s, lvl, acc, cap, cap_s, vis;

  logic wr_func, wr_en_r, wr_byp, wr_pol, wr_stat;
  assign wr_func = wr_en && (addr == RA_FUNC);
  assign wr_en_r = wr_en && (addr == RA_ENABLE);
  assign wr_byp  = wr_en && (addr == RA_BYPASS);
  assign wr_pol  = wr_en && (addr == RA_POL);
  assign wr_stat = wr_en && (addr == RA_STATUS);
  assign clr_now = wr_stat ? wr_data[NPINS-1:0] : '0;

  btn_sync2 #(.W(NPINS)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(pins), .q(pin_s));
  btn_sync2 #(.W(NPINS)) u_cap_sync (
    .clk(clk), .rst_n(rst_n), .d(cap), .q(cap_s));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign active[i] = (sel_q[i*SEL_W +: SEL_W] == SEL_W'(FUNC_BUTTON));

    btn_debounce #(.TICKS(DEB_TICKS)) u_deb (
      .clk(clk), .rst_n(rst_n), .tick(sample_tick),
      .din(pin_s[i]), .lvl(lvl[i]), .accept(acc[i]));

    assign evt[i]     = acc[i] & ~byp_q[i] & active[i] & (pin_s[i] ^ pol_q[i]);
    assign arm[i]     = active[i] & byp_q[i];
    assign aclr[i]    = ~rst_n | clr_q[i] | ~arm[i];
    assign edge_in[i] = pins[i] ^ pol_q[i];

    btn_wake_latch u_wake (
      .edge_in(edge_in[i]), .aclr(aclr[i]), .q(cap[i]));

    assign st_n[i] = byp_q[i] ? 1'b0 : ((st_q[i] & ~clr_now[i]) | evt[i]);
    assign vis[i]  = byp_q[i] ? cap_s[i] : st_q[i];

    AST_SET_ONLY_BUTTON: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q[i]) |-> $past(active[i])); // R2
    AST_STICKY_UNTIL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(st_q[i]) |-> $past(clr_now[i] | byp_q[i])); // R5
    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> st_q[i]); // R6
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      en_q  <= '0;
      byp_q <= '0;
      pol_q <= '0;
      st_q  <= '0;
      clr_q <= '0;
    end else begin
      if (wr_func) sel_q <= wr_data[SELB-1:0];
      if (wr_en_r) en_q  <= wr_data[NPINS-1:0];
      if (wr_byp)  byp_q <= wr_data[NPINS-1:0];
      if (wr_pol)  pol_q <= wr_data[NPINS-1:0];
      st_q  <= st_n;
      clr_q <= clr_now;
    end
  end

  always_comb begin
    rd_data = '0;
    case (addr)
      RA_FUNC:   rd_data[SELB-1:0]  = sel_q;
      RA_ENABLE: rd_data[NPINS-1:0] = en_q;
      RA_BYPASS: rd_data[NPINS-1:0] = byp_q;
      RA_POL:    rd_data[NPINS-1:0] = pol_q;
      RA_STATUS: rd_data[NPINS-1:0] = vis;
      default:   rd_data = '0;
    endcase
  end

  assign irq = |(en_q & ((byp_q & cap) | (~byp_q & st_q)));

  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_q != '0)); // R7
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && byp_q == '0) |-> (st_q != '0)); // R1
endmodule

// File: tb/btn_irq_ctrl_test.sv
module btn_irq_ctrl_test;
  logic        clk = 1'b0, clk_run = 1'b1;
  logic        rst_n = 1'b0, sample_tick = 1'b0, wr_en = 1'b0;
  logic [3:0]  pins = '0;
  logic [2:0]  addr = '0;
  logic [15:0] wr_data = '0, rd_data, rv;
  logic        irq;
  int checks = 0, errors = 0;

  btn_irq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .pins(pins),
    .wr_en(wr_en), .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq));

  always begin
    #4;
    if (clk_run) clk = ~clk;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); sample_tick = 1'b1;
      @(negedge clk); sample_tick = 1'b0;
      cyc(2);
    end
  endtask

  // Row fields: {pol, init level, final level, hold ticks[2:0], expected event}
  localparam logic [6:0] VEC [6] = '{
    {1'b0, 1'b0, 1'b1, 3'd4, 1'b1},
    {1'b0, 1'b0, 1'b1, 3'd3, 1'b0},
    {1'b1, 1'b1, 1'b0, 3'd4, 1'b1},
    {1'b1, 1'b1, 1'b0, 3'd2, 1'b0},
    {1'b0, 1'b1, 1'b0, 3'd5, 1'b0},
    {1'b1, 1'b0, 1'b1, 3'd4, 1'b0}
  };

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    // R10: reset state and unmapped addresses
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), rv);
      check("R10 register reset", rv, 16'h0);
    end
    check("R10 irq reset", {15'b0, irq}, 16'h0);

    // Table: R3 filter length and R4 polarity on pin 0, enable on
    wr(3'd1, 16'h1);
    foreach (VEC[v]) begin
      wr(3'd3, {15'b0, VEC[v][6]});
      pins[0] = VEC[v][5];
      cyc(3); ticks(6);
      wr(3'd4, 16'hF);
      pins[0] = VEC[v][4];
      cyc(3); ticks(int'(VEC[v][3:1]));
      cyc(2);
      rd(3'd4, rv);
      check("R3/R4 status after hold", {15'b0, rv[0]}, {15'b0, VEC[v][0]});
      check("R1/R4 irq after hold", {15'b0, irq}, {15'b0, VEC[v][0]});
    end

    // Return pin 0 to low, rising polarity, clean status
    wr(3'd3, 16'h0);
    pins = 4'b0000;
    cyc(3); ticks(6);
    wr(3'd4, 16'hF);

    // R2: a non-button function code blocks events
    wr(3'd0, 16'h0003);
    pins[0] = 1'b1;
    cyc(3); ticks(6);
    rd(3'd4, rv);
    check("R2 status with function code 3", rv, 16'h0);
    check("R2 irq with function code 3", {15'b0, irq}, 16'h0);
    wr(3'd0, 16'h0000);

    // R7: disabled pin sets status but not irq
    wr(3'd1, 16'h0);
    pins[1] = 1'b1;
    cyc(3); ticks(6);
    rd(3'd4, rv);
    check("R7 status bit1 while disabled", rv, 16'h2);
    check("R7 irq while disabled", {15'b0, irq}, 16'h0);
    wr(3'd1, 16'h2);
    cyc(1);
    check("R1 irq after enabling set pin", {15'b0, irq}, 16'h1);

    // R5: set pin 0 too, then clear only bit 1
    pins[0] = 1'b0; cyc(3); ticks(6);
    pins[0] = 1'b1; cyc(3); ticks(6);
    rd(3'd4, rv);
    check("R5 both bits set", rv, 16'h3);
    wr(3'd4, 16'h2);
    rd(3'd4, rv);
    check("R5 write-1 clears only its bit", rv, 16'h1);
    check("R1 irq follows enabled bit only", {15'b0, irq}, 16'h0);
    wr(3'd4, 16'hF);

    // R6: event and clear in the same cycle on pin 2
    pins[2] = 1'b1;
    cyc(3); ticks(3);
    @(negedge clk);
    sample_tick = 1'b1; wr_en = 1'b1; addr = 3'd4; wr_data = 16'h4;
    @(negedge clk);
    sample_tick = 1'b0; wr_en = 1'b0;
    rd(3'd4, rv);
    check("R6 event beats clear", rv, 16'h4);
    wr(3'd4, 16'hF);

    // R8/R9: bypass on pin 0, wake with the clock stopped
    pins[0] = 1'b0;
    cyc(3); ticks(6);
    wr(3'd3, 16'h0);
    wr(3'd2, 16'h1);
    wr(3'd1, 16'h1);
    wr(3'd4, 16'hF);
    cyc(4);
    rd(3'd4, rv);
    check("R9 bypass status starts clear", rv, 16'h0);
    @(negedge clk);
    clk_run = 1'b0;
    #40;
    pins[0] = 1'b1;
    #10;
    check("R8 irq with clock stopped", {15'b0, irq}, 16'h1);
    clk_run = 1'b1;
    cyc(4);
    rd(3'd4, rv);
    check("R9 bypass status readback", rv, 16'h1);
    wr(3'd4, 16'h1);
    cyc(4);
    rd(3'd4, rv);
    check("R9 bypass status cleared", rv, 16'h0);
    check("R9 irq falls after clear", {15'b0, irq}, 16'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule